// File: doc/BRIEF.md
# Fan Spin-Up Supervisor and Stall Flag

This block supervises a single cooling fan from the moment it is enabled. While the fan is spinning up, it drives the PWM output fully on and ignores the normal duty-cycle waveform. It keeps doing so until the synchronized tachometer input shows two qualified rising edges. If a startup timeout is configured and runs out first, the fan is declared stalled. A stalled fan's tach count reads as the sentinel 0xFFFF, and the next measurement raises the fault flag.

In normal running, each period measurement from an external counter is compared against a 16-bit minimum-speed limit, which is written as two bytes. A count above the limit means the fan is too slow, and it sets a sticky fault bit. A limit of 0x0000 or 0xFFFF turns the check off. The fault bit is cleared by a clear pulse, but only when the newest comparison is no longer over the limit. The timeout code is selected from an eight-entry table of millisecond values counted on an external 1 ms tick. Writes to the timeout code can be locked. Writes to the limit bytes cannot be locked.

The controller has four phases, reported on `phase` as IDLE=0, SPINUP=1, RUN=2 and STALLED=3. The transitions are:
- IDLE→SPINUP when the fan is enabled.
- SPINUP→RUN on the second qualified edge.
- SPINUP→STALLED when the timeout expires. The edge wins if both happen in the same cycle.
- Any phase→IDLE when the enable drops.

Top module: `fan_spinup_guard`

## Requirements
- R1: `pwm_out` is 0 in IDLE and 1 throughout SPINUP, whatever `pwm_req` is. In RUN and STALLED, `pwm_out` follows `pwm_req`.
- R2: SPINUP moves to RUN in the cycle after the second qualified tach rising edge since entering SPINUP.
- R3: `tach_in` passes through two synchronizer flops. A synchronized rising edge counts only after at least two consecutive synchronized low samples, so a one-cycle low dip followed by a rise is not counted.
- R4: The timeout code selects 0 (never), 100, 250, 400, 667, 1000, 2000 or 4000 ticks of `ms_tick` for codes 0 to 7. While in SPINUP, the ticks are counted, and reaching the selected value moves the phase to STALLED. Code 0 never times out.
- R5: In STALLED, `count_out` reads 0xFFFF, and a `count_valid` pulse sets `fault` when the limit is enabled.
- R6: In RUN, a `count_valid` pulse whose `count_in` is strictly greater than the limit {high byte, low byte} sets `fault`. A count equal to or below the limit does not set it. In RUN, `count_out` equals `count_in`.
- R7: When the limit is 0x0000 or 0xFFFF, `fault` is never set, in any phase.
- R8: `fault` is sticky. A `fault_clr` pulse clears it only if the latest comparison is not over the limit. A comparison in the same cycle as `fault_clr` counts as the latest, and a set takes priority over the clear.
- R9: After reset, the phase is IDLE, the timeout code is 2 (250), the limit is 0xFFFF and `fault` is 0.
- R10: While `cfg_lock` is 1, writes to the timeout code are ignored. Limit byte writes always take effect.
- R11: When `fan_en` is low, the phase becomes IDLE at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| fan_en | input | 1 | Fan enable |
| tach_in | input | 1 | Asynchronous tachometer input |
| pwm_req | input | 1 | Normal PWM waveform from the duty generator |
| pwm_out | output | 1 | PWM drive to the fan |
| cfg_lock | input | 1 | Blocks timeout-code writes |
| tmo_we | input | 1 | Timeout-code write strobe |
| tmo_wdata | input | 3 | Timeout-code write data |
| tmo_code | output | 3 | Current timeout code |
| lim_lo_we | input | 1 | Limit low-byte write strobe |
| lim_hi_we | input | 1 | Limit high-byte write strobe |
| lim_wdata | input | 8 | Limit byte write data |
| lim_value | output | 16 | Current limit {high, low} |
| count_valid | input | 1 | Measurement-ready pulse |
| count_in | input | 16 | Measured tach period count |
| count_out | output | 16 | Reported tach count (0xFFFF when stalled) |
| fault_clr | input | 1 | Fault clear pulse |
| fault | output | 1 | Sticky fan fault flag |
| phase | output | 2 | Controller phase (0 IDLE, 1 SPINUP, 2 RUN, 3 STALLED) |

## Verification
The critical collision is a fault set and a fault clear in the same cycle. This happens when `fault_clr` arrives together with a `count_valid` measurement. The bench provokes it twice. The first time, the measurement is over the limit, and `fault` must stay 1. The second time, the measurement is under the limit, and the clear must succeed in that same edge. A separate check issues a clear while the previous comparison is still over the limit, to show that the clear is refused.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam int TMR_W = 12;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SPIN  = 2'd1,
        PH_RUN   = 2'd2,
        PH_STALL = 2'd3
    } phase_t;

    function automatic logic [TMR_W-1:0] tmo_ticks(input logic [2:0] code);
        logic [TMR_W-1:0] t;
        unique case (code)
            3'd0: t = TMR_W'(0);
            3'd1: t = TMR_W'(100);
            3'd2: t = TMR_W'(250);
            3'd3: t = TMR_W'(400);
            3'd4: t = TMR_W'(667);
            3'd5: t = TMR_W'(1000);
            3'd6: t = TMR_W'(2000);
            default: t = TMR_W'(4000);
        endcase
        return t;
    endfunction
endpackage

// File: rtl/fsg_tach_qual.sv
module fsg_tach_qual #(
    parameter int SYNC    = 2,
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_in,
    output logic edge_ok
);
    localparam int LW = $clog2(MIN_LOW + 1);

    logic [SYNC-1:0] s_q;
    logic [LW-1:0]   low_cnt;

    genvar g;
    generate
        for (g = 0; g < SYNC; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) s_q[g] <= 1'b0;
                else if (g == 0) s_q[g] <= tach_in;
                else s_q[g] <= s_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (s_q[SYNC-1])
            low_cnt <= '0;
        else if (low_cnt < LW'(MIN_LOW))
            low_cnt <= low_cnt + 1'b1;
    end

    assign edge_ok = s_q[SYNC-1] && (low_cnt >= LW'(MIN_LOW));

    // Checks the default two-sample low requirement.
    AST_EDGE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        edge_ok |-> ($past(s_q[SYNC-1]) == 1'b0) && ($past(s_q[SYNC-1], 2) == 1'b0)); // R3
endmodule

// File: rtl/fsg_spin_timer.sv
module fsg_spin_timer
    import fsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic [2:0] code,
    output logic       expired
);
    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] lim;

    assign lim = tmo_ticks(code);

    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (tick && (cnt_q != '1))
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (lim != '0) && (cnt_q >= lim);

    AST_NEVER_EXPIRE_CODE0: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'd0) |-> !expired); // R4
endmodule

// File: rtl/fsg_limit_check.sv
module fsg_limit_check (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lo_we,
    input  logic        hi_we,
    input  logic [7:0]  wdata,
    input  logic        count_valid,
    input  logic [15:0] count_in,
    input  logic        judge,
    input  logic        stalled,
    input  logic        idle,
    input  logic        fault_clr,
    output logic [15:0] lim,
    output logic        fault
);
    logic [7:0] lo_q, hi_q;
    logic       over_last, lim_ok, over_new, meas, cond_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= 8'hFF;
            hi_q <= 8'hFF;
        end else begin
            if (lo_we) lo_q <= wdata;
            if (hi_we) hi_q <= wdata;
        end
    end

    assign lim      = {hi_q, lo_q};
    assign lim_ok   = (lim != 16'h0000) && (lim != 16'hFFFF);
    assign over_new = lim_ok && (stalled || (count_in > lim));
    assign meas     = count_valid && judge;
    assign cond_now = meas ? over_new : over_last;

    always_ff @(posedge clk) begin
        if (!rst_n || idle)
            over_last <= 1'b0;
        else if (meas)
            over_last <= over_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            fault <= 1'b0;
        else if (meas && over_new)
            fault <= 1'b1;
        else if (fault_clr && !cond_now)
            fault <= 1'b0;
    end

    AST_SET_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> ($past(lim) != 16'h0000) && ($past(lim) != 16'hFFFF)); // R7
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> fault); // R8
    AST_STALL_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (count_valid && judge && stalled && lim_ok) |=> fault); // R5
endmodule

// File: rtl/fan_spinup_guard.sv
module fan_spinup_guard
    import fsg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ms_tick,
    input  logic        fan_en,
    input  logic        tach_in,
    input  logic        pwm_req,
    output logic        pwm_out,
    input  logic        cfg_lock,
    input  logic        tmo_we,
    input  logic [2:0]  tmo_wdata,
    output logic [2:0]  tmo_code,
    input  logic        lim_lo_we,
    input  logic        lim_hi_we,
    input  logic [7:0]  lim_wdata,
    output logic [15:0] lim_value,
    input  logic        count_valid,
    input  logic [15:0] count_in,
    output logic [15:0] count_out,
    input  logic        fault_clr,
    output logic        fault,
    output logic [1:0]  phase
);
    phase_t state_q, state_d;
    logic   edge_ok, expired, seen_q;
    logic [2:0] tmo_q;

    fsg_tach_qual #(.SYNC(2), .MIN_LOW(2)) u_qual (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .edge_ok(edge_ok)
    );

    fsg_spin_timer u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state_q == PH_SPIN),
        .tick(ms_tick), .code(tmo_q), .expired(expired)
    );

    fsg_limit_check u_lim (
        .clk(clk), .rst_n(rst_n), .lo_we(lim_lo_we), .hi_we(lim_hi_we),
        .wdata(lim_wdata), .count_valid(count_valid), .count_in(count_in),
        .judge((state_q == PH_RUN) || (state_q == PH_STALL)),
        .stalled(state_q == PH_STALL), .idle(state_q == PH_IDLE),
        .fault_clr(fault_clr), .lim(lim_value), .fault(fault)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            tmo_q <= 3'd2;
        else if (tmo_we && !cfg_lock)
            tmo_q <= tmo_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q != PH_SPIN)
            seen_q <= 1'b0;
        else if (edge_ok)
            seen_q <= 1'b1;
    end

    always_comb begin
        state_d = state_q;
        if (!fan_en)
            state_d = PH_IDLE;
        else begin
            unique case (state_q)
                PH_IDLE:  state_d = PH_SPIN;
                PH_SPIN: begin
                    if (edge_ok && seen_q) state_d = PH_RUN;
                    else if (expired)      state_d = PH_STALL;
                end
                PH_RUN:   state_d = PH_RUN;
                PH_STALL: state_d = PH_STALL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pwm_out   = 1'b0;
        count_out = count_in;
        unique case (state_q)
            PH_IDLE:  pwm_out = 1'b0;
            PH_SPIN:  pwm_out = 1'b1;
            PH_RUN:   pwm_out = pwm_req;
            PH_STALL: begin
                pwm_out   = pwm_req;
                count_out = 16'hFFFF;
            end
        endcase
    end

    assign tmo_code = tmo_q;
    assign phase    = state_q;

    AST_RUN_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_RUN && $past(state_q) == PH_SPIN) |-> $past(edge_ok)); // R2
    AST_STALL_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_STALL && $past(state_q) == PH_SPIN) |-> ($past(tmo_q) != 3'd0)); // R4
    AST_DISABLE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fan_en |=> (state_q == PH_IDLE)); // R11
    AST_SPIN_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == PH_IDLE && state_q == PH_SPIN) |-> pwm_out); // R1
endmodule

// File: tb/sim_fan_spinup_guard.sv
module sim_fan_spinup_guard;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 0, fan_en = 0, tach_in = 0, pwm_req = 0;
    logic cfg_lock = 0, tmo_we = 0, lim_lo_we = 0, lim_hi_we = 0;
    logic [2:0] tmo_wdata = '0;
    logic [7:0] lim_wdata = '0;
    logic count_valid = 0, fault_clr = 0;
    logic [15:0] count_in = '0;
    logic pwm_out, fault;
    logic [2:0] tmo_code;
    logic [15:0] lim_value, count_out;
    logic [1:0] phase;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    fan_spinup_guard u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .fan_en(fan_en),
        .tach_in(tach_in), .pwm_req(pwm_req), .pwm_out(pwm_out),
        .cfg_lock(cfg_lock), .tmo_we(tmo_we), .tmo_wdata(tmo_wdata),
        .tmo_code(tmo_code), .lim_lo_we(lim_lo_we), .lim_hi_we(lim_hi_we),
        .lim_wdata(lim_wdata), .lim_value(lim_value),
        .count_valid(count_valid), .count_in(count_in), .count_out(count_out),
        .fault_clr(fault_clr), .fault(fault), .phase(phase)
    );

    // {limit, count, expected fault}
    localparam logic [32:0] VEC [8] = '{
        {16'h1000, 16'h0FFF, 1'b0},
        {16'h1000, 16'h1000, 1'b0},
        {16'h1000, 16'h1001, 1'b1},
        {16'h0000, 16'hFFFF, 1'b0},
        {16'hFFFF, 16'hFFFF, 1'b0},
        {16'h0001, 16'h0002, 1'b1},
        {16'h8000, 16'hFFFE, 1'b1},
        {16'hFFFE, 16'hFFFF, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_lim(input logic [15:0] v);
        lim_wdata = v[7:0]; lim_lo_we = 1; step(1); lim_lo_we = 0;
        lim_wdata = v[15:8]; lim_hi_we = 1; step(1); lim_hi_we = 0;
    endtask

    task automatic measure(input logic [15:0] c, input logic clr);
        count_in = c; count_valid = 1; fault_clr = clr; step(1);
        count_valid = 0; fault_clr = 0;
    endtask

    task automatic tach_pulse();
        tach_in = 0; step(6); tach_in = 1; step(6);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1; step(1); ms_tick = 0; step(3);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3); rst_n = 1; step(1);
        // R9 reset state
        check("R9 phase", phase, 0);
        check("R9 tmo", tmo_code, 2);
        check("R9 lim", lim_value, 16'hFFFF);
        check("R9 fault", fault, 0);
        check("R1 idle pwm", pwm_out, 0);

        write_lim(16'h1000);
        fan_en = 1; pwm_req = 0; step(1);
        check("R1 spinup phase", phase, 1);
        check("R1 spinup forced", pwm_out, 1);

        tach_pulse();                      // first qualified edge
        tach_in = 0; step(1); tach_in = 1; step(6);   // one-sample dip
        check("R3 dip ignored", phase, 1);
        tach_pulse();                      // second qualified edge
        check("R2 run", phase, 2);
        pwm_req = 1; step(1);
        check("R1 run follow hi", pwm_out, 1);
        pwm_req = 0; step(1);
        check("R1 run follow lo", pwm_out, 0);

        for (int i = 0; i < 8; i++) begin
            write_lim(VEC[i][32:17]);
            count_in = VEC[i][16:1]; count_valid = 1; step(0);
            #0 check("R6 count_out", count_out, VEC[i][16:1]);
            step(1); count_valid = 0;
            check((VEC[i][32:17] == 16'h0 || VEC[i][32:17] == 16'hFFFF) ? "R7 vec" : "R6 vec",
                  fault, VEC[i][0]);
            measure(16'h0000, 0);
            fault_clr = 1; step(1); fault_clr = 0;
            check("R8 clr ok", fault, 0);
        end

        write_lim(16'h1000);
        measure(16'h2000, 0);
        check("R6 set", fault, 1);
        fault_clr = 1; step(1); fault_clr = 0;
        check("R8 clr refused", fault, 1);
        measure(16'h3000, 1);
        check("R8 set wins", fault, 1);
        measure(16'h0010, 1);
        check("R8 same-cycle clr", fault, 0);

        fan_en = 0; step(1);
        check("R11 idle", phase, 0);
        check("R1 idle pwm", pwm_out, 0);

        tmo_wdata = 3'd1; tmo_we = 1; step(1); tmo_we = 0;
        fan_en = 1; tach_in = 0; step(1);
        wait_ticks(90);
        check("R4 not yet", phase, 1);
        wait_ticks(15);
        check("R4 stalled", phase, 3);
        count_in = 16'h1234; step(1);
        check("R5 sentinel", count_out, 16'hFFFF);
        measure(16'h1234, 0);
        check("R5 stall fault", fault, 1);
        write_lim(16'hFFFF);
        measure(16'h0, 1);
        check("R7 clr", fault, 0);
        measure(16'h1234, 0);
        check("R7 stalled suppressed", fault, 0);

        fan_en = 0; step(1);
        cfg_lock = 1; tmo_wdata = 3'd0; tmo_we = 1; step(1); tmo_we = 0;
        check("R10 locked tmo", tmo_code, 1);
        lim_wdata = 8'h34; lim_lo_we = 1; step(1); lim_lo_we = 0;
        check("R10 lim writable", lim_value, 16'hFF34);
        cfg_lock = 0; tmo_we = 1; step(1); tmo_we = 0;
        check("R10 unlocked tmo", tmo_code, 0);
        fan_en = 1; step(1);
        wait_ticks(300);
        check("R4 code0 no timeout", phase, 1);

        fan_en = 0; step(1);
        tmo_wdata = 3'd3; tmo_we = 1; step(1); tmo_we = 0;
        fan_en = 1; step(1);
        wait_ticks(395);
        check("R4 400 not yet", phase, 1);
        wait_ticks(10);
        check("R4 400 stalled", phase, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule